// File: doc/BRIEF.md
# Programmable Audio Sample Delay

This block holds back a stream of 12-bit audio samples by a chosen number of sample periods. Samples arrive in the system clock domain together with a one-cycle strobe. Each strobe stores the new sample in a ring of storage words and, in the same cycle, reads the word that was stored a set number of strobes earlier. The ring wraps from its last word back to its first. The delayed word drives the output, and the output holds its value until the next strobe.

The ring depth is a parameter. An instance sized for one second of audio at 20 kHz uses a depth of 20000. The delay can be changed at run time between one sample and the full ring depth, and a new setting applies from the next strobe. After reset the output stays at zero until enough samples have been written to fill the selected delay, so words left in storage from before the reset are never played.

Top module: `audio_delay_line`

## Requirements
- R1: While reset is active, and after it is released until the first strobe that finds enough stored history, the output is zero.
- R2: With an effective delay D, the output after the strobe that carries the k-th sample since reset (counting from 0) equals sample k-D whenever k is at least D.
- R3: Between strobes the output does not change.
- R4: A delay setting of 0 behaves as a delay of 1.
- R5: A delay setting above the ring depth behaves as a delay equal to the ring depth.
- R6: The output after the strobe carrying sample k is zero when k is less than the effective delay D.
- R7: A delay equal to the ring depth works across the wrap of the write position, returning the sample written exactly depth strobes earlier.
- R8: A change of the delay setting applies at the very next strobe, with no settling period.
- R9: Cycles without a strobe write nothing and advance nothing, so idle gaps of any length leave the delay counted in strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_vld | input | 1 | One-cycle strobe that marks a new input sample |
| smp_in | input | DATA_W (12) | Incoming audio sample |
| dly_sel | input | DLY_W | Requested delay in samples, sampled on each strobe |
| smp_out | output | DATA_W (12) | Delayed audio sample |

## Verification
A write and a read of the same storage word can fall in the same cycle. This happens when the delay equals the ring depth, because the read position then equals the write position. The bench provokes this with a setting equal to the depth and with one above it, runs well past several wraps, and expects the word from exactly one ring length earlier, not the sample just written. A change of the delay setting can also fall on the same strobe as a new sample, so the bench moves the setting from one strobe to the next. It expects the new offset at once, and a zero wherever the history written so far is shorter than the new delay.

// File: rtl/adl_pkg.sv
package adl_pkg;

  // Map a requested delay into the legal range 1..depth.
  function automatic int unsigned adl_clamp(int unsigned req, int unsigned depth);
    if (req == 0) return 1;
    if (req > depth) return depth;
    return req;
  endfunction

  // Step back d positions from idx on a ring of the given depth (1 <= d <= depth).
  function automatic int unsigned adl_back(int unsigned idx, int unsigned d,
                                           int unsigned depth);
    int unsigned t;
    t = idx + depth - d;
    if (t >= depth) t = t - depth;
    return t;
  endfunction

endpackage

// File: rtl/adl_ring_mem.sv
module adl_ring_mem #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 2048,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     wa,
  input  logic [DATA_W-1:0] wd,
  input  logic              re,
  input  logic [AW-1:0]     ra,
  output logic [DATA_W-1:0] rd
);

  logic [DATA_W-1:0] store [DEPTH];

  // Storage carries no reset; reads are gated by the history flag upstream.
  always_ff @(posedge clk) begin
    if (we) store[wa] <= wd;
  end

  // Synchronous read returns the old word when ra equals wa.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd <= '0;
    else if (re) rd <= store[ra];
  end

endmodule

// File: rtl/adl_ptr_ctrl.sv
module adl_ptr_ctrl
  import adl_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int AW    = $clog2(DEPTH),
  parameter int DLY_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [DLY_W-1:0] dly_req,
  output logic [AW-1:0]    wr_idx,
  output logic [AW-1:0]    rd_idx,
  output logic             hist_ok
);

  localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);
  localparam logic [DLY_W-1:0] FULL_CNT = DLY_W'(DEPTH);

  logic [DLY_W-1:0] dly_eff;
  logic [DLY_W-1:0] fill_cnt;

  assign dly_eff = DLY_W'(adl_clamp(int'(dly_req), DEPTH));
  assign rd_idx  = AW'(adl_back(int'(wr_idx), int'(dly_eff), DEPTH));
  assign hist_ok = (fill_cnt >= dly_eff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_idx   <= '0;
      fill_cnt <= '0;
    end else if (step) begin
      wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
      if (fill_cnt != FULL_CNT) fill_cnt <= fill_cnt + 1'b1;
    end
  end

  assert_wr_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && wr_idx == LAST_IDX) |=> (wr_idx == '0));

  assert_wr_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(wr_idx) && $stable(fill_cnt));

  assert_fill_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= FULL_CNT);

  assert_rd_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_idx) < DEPTH);

endmodule

// File: rtl/audio_delay_line.sv
module audio_delay_line #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 2048,
  parameter int DLY_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp_in,
  input  logic [DLY_W-1:0]  dly_sel,
  output logic [DATA_W-1:0] smp_out
);

  localparam int AW = $clog2(DEPTH);

  logic [AW-1:0]     wr_idx;
  logic [AW-1:0]     rd_idx;
  logic              hist_ok;
  logic              tap_ok_q;
  logic [DATA_W-1:0] tap_word;

  adl_ptr_ctrl #(.DEPTH(DEPTH), .AW(AW), .DLY_W(DLY_W)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (smp_vld),
    .dly_req (dly_sel),
    .wr_idx  (wr_idx),
    .rd_idx  (rd_idx),
    .hist_ok (hist_ok)
  );

  adl_ring_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (smp_vld),
    .wa    (wr_idx),
    .wd    (smp_in),
    .re    (smp_vld),
    .ra    (rd_idx),
    .rd    (tap_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tap_ok_q <= 1'b0;
    else if (smp_vld) tap_ok_q <= hist_ok;
  end

  assign smp_out = tap_ok_q ? tap_word : '0;

  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(smp_out));

  assert_no_stale_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !hist_ok) |=> (smp_out == '0));

endmodule

// File: tb/audio_delay_line_tb_top.sv
`timescale 1ns/1ps
module audio_delay_line_tb_top;

  localparam int DATA_W = 12;
  localparam int DEPTH  = 32;
  localparam int DLY_W  = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              smp_vld = 1'b0;
  logic [DATA_W-1:0] smp_in = '0;
  logic [DLY_W-1:0]  dly_sel = '0;
  logic [DATA_W-1:0] smp_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [DATA_W-1:0] hist[$];
  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];
  logic              took_q = 1'b0;
  logic [DATA_W-1:0] last_out = '0;

  always #2.5 clk = ~clk;

  audio_delay_line #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DLY_W(DLY_W)) dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_vld (smp_vld),
    .smp_in  (smp_in),
    .dly_sel (dly_sel),
    .smp_out (smp_out)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: computes the expected output from the sample history and queues it.
  task automatic send(input logic [DATA_W-1:0] x, input int dsel,
                      input string tag, input int gap);
    int d;
    logic [DATA_W-1:0] e;
    d = (dsel == 0) ? 1 : ((dsel > DEPTH) ? DEPTH : dsel);
    e = (hist.size() >= d) ? hist[hist.size() - d] : '0;
    hist.push_back(x);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    smp_vld = 1'b1;
    smp_in  = x;
    dly_sel = DLY_W'(dsel);
    @(negedge clk);
    smp_vld = 1'b0;
    smp_in  = DATA_W'($urandom);
    repeat (gap) @(negedge clk);
  endtask

  always @(posedge clk) took_q <= smp_vld && rst_n;

  // Monitor: compares after each strobe, checks holding between strobes (R3).
  always @(negedge clk) begin
    if (!rst_n) begin
      last_out = '0;
    end else if (took_q) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected strobe", smp_out, last_out);
      end else begin
        check(tag_q.pop_front(), smp_out, exp_q.pop_front());
      end
      last_out = smp_out;
    end else begin
      check("R3 hold", smp_out, last_out);
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", smp_out, '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", smp_out, '0);

    // R6 then R2: fill phase and steady delay of 5, back to back and with gaps
    for (int i = 0; i < 40; i++) send(DATA_W'(i * 37 + 1), 5, "R2 R6 delay5", i % 3);

    // R4: setting 0 means one sample
    for (int i = 0; i < 10; i++) send(DATA_W'($urandom), 0, "R4 zero setting", 0);

    // R8: delay changes on consecutive strobes
    for (int i = 0; i < 20; i++) send(DATA_W'($urandom), 3 + (i % 4) * 4, "R8 live change", i % 2);

    // R5: above depth clamps to depth, crossing wraps
    for (int i = 0; i < 70; i++) send(DATA_W'($urandom), 60, "R5 clamp high", 0);

    // R7: delay exactly equal to depth, write and read on the same word
    for (int i = 0; i < 70; i++) send(DATA_W'($urandom), DEPTH, "R7 full ring", i % 2);

    // R9: long idle gaps do not move the delay
    for (int i = 0; i < 12; i++) send(DATA_W'($urandom), 7, "R9 idle gaps", 5 + i);

    // Reset mid-stream: history restarts (R1, R6)
    @(negedge clk);
    rst_n = 1'b0;
    hist.delete();
    repeat (2) @(negedge clk);
    check("R1 mid reset", smp_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 30; i++) send(DATA_W'($urandom), 9, "R6 refill", 1);
    for (int i = 0; i < 10; i++) send(DATA_W'($urandom), 40, "R5 R6 large after refill", 0);

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) check("R2 drained", 12'(exp_q.size()), '0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule